// File: doc/BRIEF.md
# Host Parallel Port with DMA Handshake

This block connects an external byte-wide host bus to a 16-bit data word and a 16-bit status word inside a signal-processing core. The host picks the data word or the status word with a chip select and a register-select line. It moves one byte per read or write strobe. The data word can be exchanged either as single bytes (narrow mode) or as two bytes in a row (wide mode). In wide mode an internal phase bit tracks which half comes next.

A turn flag coordinates the two sides. The core raises it each time it reads or writes the data word, which hands the word to the host. The host lowers it when it finishes its transfer. In DMA mode the turn flag drives a request line to a DMA controller. That controller's acknowledge then acts as a data-word select, and its completed transfer drops the request. The core writes the software-owned status bits directly. Taking an interrupt clears the interrupt-enable bit.

All host inputs are sampled on the block clock. An access is acted on when its strobe is seen to rise.

Top module: `hostpar_port`

## Requirements
- R1: With `host_sel_n` low, `host_stat_sel` = 0 selects the data word for read or write, and `host_stat_sel` = 1 selects the status word for read only. A host write to the status word changes nothing.
- R2: The status word is laid out as: bit 15 turn flag, 14 user flag 1, 13 user flag 0, 12 byte phase, 11 DMA enable, 10 narrow data mode, 9 narrow serial-out mode, 8 narrow serial-in mode, 7 interrupt enable, 1 general output 1, 0 general output 0. All other bits read 0. A host status read returns bits 15..8.
- R3: In narrow mode (bit 10 = 1), each host data transfer uses the low byte of the data word, leaves the byte phase at 0 and clears the turn flag.
- R4: In wide mode (bit 10 = 0), the first host data transfer uses the low byte and sets the byte phase to 1. The second uses the high byte, returns the byte phase to 0 and clears the turn flag.
- R5: A core write or flagged core read of the data word sets the turn flag. This takes priority over a host completion in the same cycle. A core read through the no-flag strobe leaves the turn flag unchanged.
- R6: `dma_req` equals the turn flag while DMA enable is 1, and is 0 otherwise. `dma_ack_n` low selects the data word whatever the values of `host_sel_n` and `host_stat_sel`, so a completed acknowledged transfer lowers the request.
- R7: A host access takes effect in the cycle after the clock edge at which its strobe is first sampled high after being low. Nothing changes while the strobe is held low.
- R8: An access during which both strobes were low at the same time is discarded.
- R9: A core status write updates only bits 14, 13, 11..7, 1 and 0. The turn flag and the byte phase change only through data transfers and core data-word strobes.
- R10: `irq_ack` clears interrupt enable in the following cycle, even if a core status write in the same cycle sets it.
- R11: `hbus_oe` is 1 only while a read strobe is low together with either select (`host_sel_n` or `dma_ack_n`) low.
- R12: After reset the data word, the status word and `dma_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel_n | input | 1 | Host chip select, active low |
| host_stat_sel | input | 1 | 0 selects the data word, 1 selects the status word |
| host_read_n | input | 1 | Host read strobe, active low |
| host_write_n | input | 1 | Host write strobe, active low |
| dma_ack_n | input | 1 | DMA acknowledge, active low; acts as a data-word select |
| hbus_in | input | BYTE_W | Byte driven by the host |
| hbus_out | output | BYTE_W | Byte returned to the host |
| hbus_oe | output | 1 | Output enable for the host bus pads |
| dma_req | output | 1 | DMA transfer request |
| core_dr_wr | input | 1 | Core write strobe for the data word |
| core_dr_wdata | input | 2*BYTE_W | Core write value for the data word |
| core_dr_rd | input | 1 | Core read strobe for the data word; sets the turn flag |
| core_dr_rd_nf | input | 1 | Core read strobe for the data word that leaves the flag alone |
| dr_rdata | output | 2*BYTE_W | Current data word |
| core_sr_wr | input | 1 | Core write strobe for the software-owned status bits |
| core_sr_wdata | input | 16 | Core write value for the status word |
| sr_rdata | output | 16 | Current status word |
| irq_ack | input | 1 | Interrupt taken; clears interrupt enable |

## Verification
The bench builds the block with the default byte width of 8, which gives a 16-bit data word made of two byte lanes. This setting reaches both wide-mode phases, mode switches between narrow and wide while the byte phase is 1, and DMA handshakes that span two bytes. Directed cases cover held strobes, overlapping strobes, status-write attempts and acknowledges that override the chip-select lines. Seeded random operations then mix core and host traffic against a reference model.

// File: rtl/hostpar_pkg.sv
// Shared constants for the host parallel port: status-word bit positions
// and the mask of bits the core may write.
package hostpar_pkg;
    localparam int SR_W         = 16;
    localparam int ST_TURN      = 15;
    localparam int ST_UF1       = 14;
    localparam int ST_UF0       = 13;
    localparam int ST_PHASE     = 12;
    localparam int ST_DMA       = 11;
    localparam int ST_NARROW    = 10;
    localparam int ST_SO_NARROW = 9;
    localparam int ST_SI_NARROW = 8;
    localparam int ST_IRQ_EN    = 7;
    localparam int ST_GPO1      = 1;
    localparam int ST_GPO0      = 0;
    localparam logic [SR_W-1:0] SR_SW_MASK = 16'h6F83;
endpackage

// File: rtl/hostpar_strobe.sv
// Host strobe tracker. Samples the host control lines on clk and reports
// one completed data-word access when a strobe rises. Assumes the host
// keeps the select lines and write data stable while the strobe is low.
// Accesses where both strobes overlapped are dropped.
module hostpar_strobe #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel_n,
    input  logic              host_stat_sel,
    input  logic              dma_ack_n,
    input  logic              host_read_n,
    input  logic              host_write_n,
    input  logic [BYTE_W-1:0] bus_in,
    output logic              xfer_done,
    output logic              xfer_write,
    output logic [BYTE_W-1:0] xfer_byte
);
    logic              rd_q, wr_q, clash_q, dsel_q;
    logic [BYTE_W-1:0] byte_q;
    logic              dsel, rd_rise, wr_rise;

    // Data-word select: acknowledge, or chip select with register select low.
    assign dsel = !dma_ack_n || (!host_sel_n && !host_stat_sel);

    // Register the previous strobe levels, select and bus byte; track overlap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q    <= 1'b1;
            wr_q    <= 1'b1;
            clash_q <= 1'b0;
            dsel_q  <= 1'b0;
            byte_q  <= '0;
        end else begin
            rd_q   <= host_read_n;
            wr_q   <= host_write_n;
            dsel_q <= dsel;
            byte_q <= bus_in;
            if (!host_read_n && !host_write_n) begin
                clash_q <= 1'b1;
            end else if (host_read_n && host_write_n) begin
                clash_q <= 1'b0;
            end
        end
    end

    // Rising-edge detection and completion qualification.
    always_comb begin
        rd_rise    = !rd_q && host_read_n;
        wr_rise    = !wr_q && host_write_n;
        xfer_done  = dsel_q && !clash_q && (rd_rise || wr_rise);
        xfer_write = wr_rise;
        xfer_byte  = byte_q;
    end
endmodule

// File: rtl/hostpar_flags.sv
// Handshake flags: the turn flag shared by host and core, and the byte
// phase used for wide transfers. Assumes at most one host completion
// per cycle; a core data-word strobe wins over a host completion.
module hostpar_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic xfer_done,
    input  logic narrow,
    input  logic core_touch,
    output logic host_turn,
    output logic byte_phase
);
    // Advance the phase on each host byte and hand the turn back to the core.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_turn  <= 1'b0;
            byte_phase <= 1'b0;
        end else begin
            if (xfer_done) begin
                if (narrow || byte_phase) begin
                    byte_phase <= 1'b0;
                    host_turn  <= 1'b0;
                end else begin
                    byte_phase <= 1'b1;
                end
            end
            if (core_touch) begin
                host_turn <= 1'b1;
            end
        end
    end

    // R3
    narrow_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && narrow && !core_touch) |=> (!host_turn && !byte_phase));
    // R4
    first_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !narrow && !byte_phase) |=> byte_phase);
    // R4
    second_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !narrow && byte_phase && !core_touch) |=> (!byte_phase && !host_turn));
    // R5
    core_touch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_touch |=> host_turn);
    // R9
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_done |=> $stable(byte_phase));
endmodule

// File: rtl/hostpar_regs.sv
// Storage for the data word (one register per byte lane) and the
// software-owned status bits. A core data write has priority over a host
// byte write in the same cycle; an interrupt acknowledge wins over a core
// status write for the interrupt-enable bit.
module hostpar_regs
    import hostpar_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_wr,
    input  logic [BYTE_W-1:0]   host_byte,
    input  logic                hi_lane,
    input  logic                core_dr_wr,
    input  logic [2*BYTE_W-1:0] core_dr_wdata,
    input  logic                core_sr_wr,
    input  logic [SR_W-1:0]     core_sr_wdata,
    input  logic                irq_ack,
    output logic [2*BYTE_W-1:0] dr_q,
    output logic [SR_W-1:0]     sw_q
);
    localparam int DW    = 2 * BYTE_W;
    localparam int NLANE = DW / BYTE_W;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        localparam bit IS_HI = (g != 0);
        logic hit;
        assign hit = host_wr && (hi_lane == IS_HI);
        // Load one byte lane from the core word or the host byte.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dr_q[g*BYTE_W +: BYTE_W] <= '0;
            end else if (core_dr_wr) begin
                dr_q[g*BYTE_W +: BYTE_W] <= core_dr_wdata[g*BYTE_W +: BYTE_W];
            end else if (hit) begin
                dr_q[g*BYTE_W +: BYTE_W] <= host_byte;
            end
        end
    end

    // Software status bits, with interrupt acknowledge clearing the enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_q <= '0;
        end else begin
            if (core_sr_wr) begin
                sw_q <= core_sr_wdata & SR_SW_MASK;
            end
            if (irq_ack) begin
                sw_q[ST_IRQ_EN] <= 1'b0;
            end
        end
    end

    // R10
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !sw_q[ST_IRQ_EN]);
    // R9
    sw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_sr_wr && !irq_ack) |=> $stable(sw_q));
    // R5
    core_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_dr_wr |=> (dr_q == $past(core_dr_wdata)));
endmodule

// File: rtl/hostpar_port.sv
// Host parallel port top. Joins the strobe tracker, handshake flags and
// register storage, builds the status word, the DMA request and the host
// read-back byte. Assumes host inputs are already synchronous to clk.
module hostpar_port
    import hostpar_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_sel_n,
    input  logic                host_stat_sel,
    input  logic                host_read_n,
    input  logic                host_write_n,
    input  logic                dma_ack_n,
    input  logic [BYTE_W-1:0]   hbus_in,
    output logic [BYTE_W-1:0]   hbus_out,
    output logic                hbus_oe,
    output logic                dma_req,
    input  logic                core_dr_wr,
    input  logic [2*BYTE_W-1:0] core_dr_wdata,
    input  logic                core_dr_rd,
    input  logic                core_dr_rd_nf,
    output logic [2*BYTE_W-1:0] dr_rdata,
    input  logic                core_sr_wr,
    input  logic [SR_W-1:0]     core_sr_wdata,
    output logic [SR_W-1:0]     sr_rdata,
    input  logic                irq_ack
);
    localparam int DW = 2 * BYTE_W;

    logic              xfer_done, xfer_write;
    logic [BYTE_W-1:0] xfer_byte;
    logic              host_turn, byte_phase, hi_lane, core_touch;
    logic [DW-1:0]     dr_q;
    logic [SR_W-1:0]   sw_q;

    hostpar_strobe #(.BYTE_W(BYTE_W)) u_strobe (
        .clk(clk), .rst_n(rst_n),
        .host_sel_n(host_sel_n), .host_stat_sel(host_stat_sel),
        .dma_ack_n(dma_ack_n), .host_read_n(host_read_n),
        .host_write_n(host_write_n), .bus_in(hbus_in),
        .xfer_done(xfer_done), .xfer_write(xfer_write), .xfer_byte(xfer_byte)
    );

    hostpar_flags u_flags (
        .clk(clk), .rst_n(rst_n), .xfer_done(xfer_done),
        .narrow(sw_q[ST_NARROW]), .core_touch(core_touch),
        .host_turn(host_turn), .byte_phase(byte_phase)
    );

    hostpar_regs #(.BYTE_W(BYTE_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .host_wr(xfer_done && xfer_write), .host_byte(xfer_byte),
        .hi_lane(hi_lane), .core_dr_wr(core_dr_wr),
        .core_dr_wdata(core_dr_wdata), .core_sr_wr(core_sr_wr),
        .core_sr_wdata(core_sr_wdata), .irq_ack(irq_ack),
        .dr_q(dr_q), .sw_q(sw_q)
    );

    // Status word assembly, DMA request and lane choice.
    always_comb begin
        core_touch         = core_dr_wr || core_dr_rd;
        hi_lane            = !sw_q[ST_NARROW] && byte_phase;
        sr_rdata           = sw_q;
        sr_rdata[ST_TURN]  = host_turn;
        sr_rdata[ST_PHASE] = byte_phase;
        dma_req            = host_turn && sw_q[ST_DMA];
        dr_rdata           = dr_q;
    end

    // Host read-back byte and pad enable.
    always_comb begin
        hbus_oe = (!host_sel_n || !dma_ack_n) && !host_read_n;
        if (!dma_ack_n || !host_stat_sel) begin
            hbus_out = hi_lane ? dr_q[DW-1 -: BYTE_W] : dr_q[BYTE_W-1:0];
        end else begin
            hbus_out = sr_rdata[SR_W-1 -: BYTE_W];
        end
    end

    // R5
    noflag_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_dr_rd_nf && !core_touch && !xfer_done) |=> $stable(host_turn));
    // R6
    dma_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_q[ST_DMA] |-> !dma_req);
endmodule

// File: tb/hostpar_port_bench.sv
module hostpar_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_sel_n = 1'b1, host_stat_sel = 1'b0;
    logic        host_read_n = 1'b1, host_write_n = 1'b1, dma_ack_n = 1'b1;
    logic [7:0]  hbus_in = '0;
    logic [7:0]  hbus_out;
    logic        hbus_oe, dma_req;
    logic        core_dr_wr = 0, core_dr_rd = 0, core_dr_rd_nf = 0;
    logic [15:0] core_dr_wdata = '0;
    logic [15:0] dr_rdata;
    logic        core_sr_wr = 0, irq_ack = 0;
    logic [15:0] core_sr_wdata = '0;
    logic [15:0] sr_rdata;

    int total = 0, bad = 0;
    bit done_flag = 0;
    logic [15:0] m_dr = '0, m_sw = '0;
    bit m_turn = 0, m_phase = 0;

    hostpar_port u_hostpar_port (
        .clk(clk), .rst_n(rst_n), .host_sel_n(host_sel_n),
        .host_stat_sel(host_stat_sel), .host_read_n(host_read_n),
        .host_write_n(host_write_n), .dma_ack_n(dma_ack_n),
        .hbus_in(hbus_in), .hbus_out(hbus_out), .hbus_oe(hbus_oe),
        .dma_req(dma_req), .core_dr_wr(core_dr_wr),
        .core_dr_wdata(core_dr_wdata), .core_dr_rd(core_dr_rd),
        .core_dr_rd_nf(core_dr_rd_nf), .dr_rdata(dr_rdata),
        .core_sr_wr(core_sr_wr), .core_sr_wdata(core_sr_wdata),
        .sr_rdata(sr_rdata), .irq_ack(irq_ack)
    );

    always #5 clk = ~clk;

    function automatic logic [15:0] exp_sr();
        return (m_sw & 16'h6F83) | (16'(m_turn) << 15) | (16'(m_phase) << 12);
    endfunction

    function automatic bit exp_hi();
        return !m_sw[10] && m_phase;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check_state(input string req);
        chk(dr_rdata === m_dr, req, dr_rdata, m_dr);
        chk(sr_rdata === exp_sr(), req, sr_rdata, exp_sr());
        chk(dma_req === (m_turn && m_sw[11]), req, dma_req, m_turn && m_sw[11]);
    endtask

    task automatic model_done();
        if (m_sw[10] || m_phase) begin
            m_phase = 0; m_turn = 0;
        end else begin
            m_phase = 1;
        end
    endtask

    task automatic core_wr(input logic [15:0] v);
        core_dr_wr = 1; core_dr_wdata = v; tick(); core_dr_wr = 0;
        m_dr = v; m_turn = 1;
    endtask

    task automatic core_rd(input bit nf);
        if (nf) core_dr_rd_nf = 1; else core_dr_rd = 1;
        tick(); core_dr_rd_nf = 0; core_dr_rd = 0;
        if (!nf) m_turn = 1;
    endtask

    task automatic sr_wr(input logic [15:0] v);
        core_sr_wr = 1; core_sr_wdata = v; tick(); core_sr_wr = 0;
        m_sw = v & 16'h6F83;
    endtask

    task automatic host_wr(input logic [7:0] b, input bit via_dma);
        if (via_dma) begin dma_ack_n = 0; host_sel_n = 1; host_stat_sel = 1; end
        else begin host_sel_n = 0; host_stat_sel = 0; end
        host_write_n = 0; hbus_in = b;
        tick(); tick();
        host_write_n = 1;
        tick();
        dma_ack_n = 1; host_sel_n = 1; host_stat_sel = 0;
        if (exp_hi()) m_dr[15:8] = b; else m_dr[7:0] = b;
        model_done();
    endtask

    task automatic host_rd(input bit stat, input bit via_dma, input string req);
        logic [7:0] e;
        if (via_dma) begin dma_ack_n = 0; host_sel_n = 1; host_stat_sel = 1; end
        else begin host_sel_n = 0; host_stat_sel = stat; end
        host_read_n = 0;
        if (stat && !via_dma) e = exp_sr() >> 8;
        else e = exp_hi() ? m_dr[15:8] : m_dr[7:0];
        tick();
        chk(hbus_oe === 1'b1, "R11", hbus_oe, 1);
        chk(hbus_out === e, req, hbus_out, e);
        tick();
        host_read_n = 1;
        tick();
        dma_ack_n = 1; host_sel_n = 1; host_stat_sel = 0;
        if (!stat || via_dma) model_done();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) tick();
        // R12: reset state
        check_state("R12");
        chk(hbus_oe === 1'b0, "R12", hbus_oe, 0);
        rst_n = 1; tick();

        // R9: only software bits take a status write
        sr_wr(16'hFFFF);
        check_state("R9");
        sr_wr(16'h0400);
        // R5: core write raises the turn flag
        core_wr(16'h1234);
        check_state("R5");
        // R2: host status read shows turn + narrow = 0x84
        host_rd(1, 0, "R2");
        check_state("R2");
        // R3: narrow read uses low byte and clears the turn
        host_rd(0, 0, "R3");
        check_state("R3");
        core_rd(0);
        check_state("R5");
        host_wr(8'hAB, 0);
        check_state("R3");
        chk(dr_rdata === 16'h12AB, "R3", dr_rdata, 16'h12AB);
        // R5: no-flag read leaves turn clear
        core_rd(1);
        check_state("R5");

        // R4 R6: wide mode with DMA
        sr_wr(16'h0800);
        core_wr(16'hBEEF);
        chk(dma_req === 1'b1, "R6", dma_req, 1);
        host_rd(0, 1, "R4");
        check_state("R4");
        chk(dma_req === 1'b1, "R6", dma_req, 1);
        host_rd(0, 1, "R4");
        check_state("R6");
        chk(dma_req === 1'b0, "R6", dma_req, 0);

        // R6: acknowledge overrides stat-select on write
        host_wr(8'h11, 1);
        host_wr(8'h22, 1);
        check_state("R6");
        chk(dr_rdata === 16'h2211, "R4", dr_rdata, 16'h2211);

        // R7: no effect while strobe held low
        core_wr(16'h5555);
        host_sel_n = 0; host_write_n = 0; hbus_in = 8'h77;
        tick(); tick(); tick();
        check_state("R7");
        host_write_n = 1;
        tick();
        host_sel_n = 1;
        m_dr[7:0] = 8'h77; model_done();
        check_state("R7");
        chk(sr_rdata[12] === 1'b1, "R7", sr_rdata[12], 1);
        // Finish the word before the overlap case.
        host_wr(8'h66, 0);

        // R8: overlapping strobes are discarded
        core_wr(16'h0F0F);
        host_sel_n = 0; host_read_n = 0; host_write_n = 0; hbus_in = 8'hC3;
        tick(); tick();
        host_write_n = 1; tick();
        host_read_n = 1; tick();
        host_sel_n = 1; tick();
        check_state("R8");

        // R1: host status write ignored
        host_sel_n = 0; host_stat_sel = 1; host_write_n = 0; hbus_in = 8'hFF;
        tick(); tick();
        host_write_n = 1; tick();
        host_sel_n = 1; host_stat_sel = 0; tick();
        check_state("R1");

        // R11: no drive without select, none without read
        host_read_n = 0; tick();
        chk(hbus_oe === 1'b0, "R11", hbus_oe, 0);
        host_read_n = 1; host_sel_n = 0; tick();
        chk(hbus_oe === 1'b0, "R11", hbus_oe, 0);
        host_sel_n = 1; tick();

        // R10: interrupt acknowledge clears enable, wins over a write
        sr_wr(16'h0080);
        irq_ack = 1; tick(); irq_ack = 0; m_sw[7] = 0;
        check_state("R10");
        core_sr_wr = 1; core_sr_wdata = 16'h0080; irq_ack = 1; tick();
        core_sr_wr = 0; irq_ack = 0; m_sw = 16'h0000;
        check_state("R10");

        // Seeded random traffic
        for (int i = 0; i < 400; i++) begin
            int op = $urandom_range(0, 8);
            case (op)
                0: core_wr(16'($urandom()));
                1: core_rd(0);
                2: core_rd(1);
                3: sr_wr(16'($urandom()) & 16'h0F83);
                4, 5: host_wr(8'($urandom()), 1'($urandom()));
                6: host_rd(0, 1'($urandom()), "R4");
                7: host_rd(1, 0, "R2");
                default: begin irq_ack = 1; tick(); irq_ack = 0; m_sw[7] = 0; end
            endcase
            check_state("R5");
        end

        done_flag = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule